// File: doc/BRIEF.md
# Bus-Snooping Bit-Manipulation Responder

This block watches a cartridge-style bus on which every clock is one processor bus cycle. It holds no memory for its own function. It follows the opcode and operand fetches that pass by. When it sees an indexed absolute load whose high operand byte names its reserved window, it takes over the data lines for the data-read cycle that follows. It then drives a value computed from the low eight address bits instead of the stored byte. Software can therefore get a bit-reversed or nibble-exchanged byte with a single indexed load from a table that does not exist: it indexes with the value it wants transformed.

The processor address bus is narrower than the full address space, so the window cannot be decoded from the address lines. The block recognises it from the fetched bytes instead. Three fetches at consecutive addresses (address wrap included) must carry the load opcode, any low operand byte, and a high operand byte of `WIN_BASE` or `WIN_BASE+1`. The block then asserts its drive enable for exactly the next cycle. Loads to any other high byte, such as the program region, are left alone.

Top module: `bitmorph_responder`

## Requirements
- R1: After reset `drive_en` is 0 and `data_out` is 0.
- R2: If three bus cycles at consecutive addresses carry the bytes 8'hBD, any byte, and 8'hD0, then in the next cycle `drive_en` is 1 and `data_out` is the low address byte `addr[7:0]` of that cycle with its bits in reverse order: output bit i equals address bit 7-i.
- R3: If the same sequence ends with the high operand byte 8'hD1, the next cycle drives `{addr[3:0], addr[7:4]}`, which is the low address byte with its two nibbles exchanged.
- R4: `drive_en` is never high for two cycles in a row. The cycle after a driven cycle is treated as idle, whatever byte is on the bus.
- R5: A sequence whose high operand byte is anything other than 8'hD0 or 8'hD1, for example 8'hF1 for a program-region load, causes no drive.
- R6: If the address of the operand fetches is not exactly one more than the previous fetch, the sequence is broken and no drive follows.
- R7: Whenever `drive_en` is 0, `data_out` is 0.
- R8: An 8'hBD byte that breaks a partial sequence starts a new sequence, and that new sequence can trigger a drive.
- R9: The consecutive-address rule wraps modulo 2^13, so address 13'h1FFF followed by 13'h0000 counts as consecutive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 13 | Address bus in the current cycle |
| data_in | input | 8 | Byte on the data bus in the current cycle |
| data_out | output | 8 | Computed byte, 0 when not driving |
| drive_en | output | 1 | High to drive `data_out` in place of the ROM |

## Verification
The hardest case to reach from the ports is the recovery case. A sequence is broken partway through and an opcode byte arrives at the same moment, so the block has to drop the old sequence and start a new one in that same cycle. The bench builds this by feeding an opcode fetch and then a second opcode byte at a non-consecutive address, followed by a valid operand pair. It also runs a sequence that straddles the top of the address space, to exercise the wrap case.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_OPC  = 2'd1,
        SQ_LOW  = 2'd2,
        SQ_HIT  = 2'd3
    } seq_state_e;

    typedef enum logic {
        XF_REVERSE = 1'b0,
        XF_SWAP    = 1'b1
    } xform_mode_e;
endpackage

// File: rtl/bmr_seq.sv
module bmr_seq
    import bmr_pkg::*;
#(
    parameter int         ADDR_W   = 13,
    parameter int         DATA_W   = 8,
    parameter logic [7:0] OPC_LOAD = 8'hBD,
    parameter logic [7:0] WIN_BASE = 8'hD0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic              hit,
    output xform_mode_e       mode
);
    typedef struct packed {
        seq_state_e       st;
        logic [ADDR_W-1:0] last;
        xform_mode_e      mode;
    } seq_t;

    seq_t s_d, s_q;
    logic [ADDR_W-1:0] next_addr;
    logic              consec;
    logic              in_win;

    always_comb begin
        next_addr = s_q.last + ADDR_W'(1);
        consec    = (addr == next_addr);
        in_win    = (data_in[DATA_W-1:1] == WIN_BASE[DATA_W-1:1]);
        s_d       = s_q;
        // default: look for a fresh opcode in this cycle
        if (data_in == OPC_LOAD) begin
            s_d.st   = SQ_OPC;
            s_d.last = addr;
        end else begin
            s_d.st = SQ_IDLE;
        end
        unique case (s_q.st)
            SQ_IDLE: ;
            SQ_OPC: begin
                if (consec) begin
                    s_d.st   = SQ_LOW;
                    s_d.last = addr;
                end
            end
            SQ_LOW: begin
                if (consec && in_win) begin
                    s_d.st   = SQ_HIT;
                    s_d.mode = xform_mode_e'(data_in[0]);
                end
            end
            SQ_HIT: s_d.st = SQ_IDLE;
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: SQ_IDLE, last: '0, mode: XF_REVERSE};
        end else begin
            s_q <= s_d;
        end
    end

    assign hit  = (s_q.st == SQ_HIT);
    assign mode = s_q.mode;
endmodule

// File: rtl/bmr_xform.sv
module bmr_xform
    import bmr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] val,
    input  xform_mode_e       mode,
    output logic [DATA_W-1:0] res
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] rev;
    logic [DATA_W-1:0] swp;

    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign rev[i] = val[DATA_W-1-i];
    end

    assign swp = {val[HALF-1:0], val[DATA_W-1:HALF]};
    assign res = (mode == XF_SWAP) ? swp : rev;
endmodule

// File: rtl/bitmorph_responder.sv
module bitmorph_responder
    import bmr_pkg::*;
#(
    parameter int         ADDR_W   = 13,
    parameter int         DATA_W   = 8,
    parameter logic [7:0] OPC_LOAD = 8'hBD,
    parameter logic [7:0] WIN_BASE = 8'hD0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [12:0]       addr,
    input  logic [7:0]        data_in,
    output logic [7:0]        data_out,
    output logic              drive_en
);
    logic              hit;
    xform_mode_e       mode;
    logic [DATA_W-1:0] xf;

    bmr_seq #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .OPC_LOAD(OPC_LOAD),
        .WIN_BASE(WIN_BASE)
    ) i_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .data_in(data_in),
        .hit    (hit),
        .mode   (mode)
    );

    bmr_xform #(.DATA_W(DATA_W)) i_xform (
        .val (addr[DATA_W-1:0]),
        .mode(mode),
        .res (xf)
    );

    assign drive_en = hit;
    assign data_out = hit ? xf : '0;
endmodule

// File: rtl/bmr_chk.sv
module bmr_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        data_in,
    input logic [7:0]        data_out,
    input logic              drive_en
);
    function automatic logic [7:0] flip8(input logic [7:0] b);
        logic [7:0] r;
        r = '0;
        for (int k = 0; k < 8; k++) r[7-k] = b[k];
        return r;
    endfunction

    // R4
    single_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |=> !drive_en);

    // R7
    quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en |-> data_out == 8'h00);

    // R5
    window_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> ($past(data_in) == 8'hD0 || $past(data_in) == 8'hD1));

    // R6
    consec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> ($past(addr) == ADDR_W'($past(addr, 2) + 1'b1)
                      && $past(data_in, 3) == 8'hBD));

    // R2
    reverse_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && $past(data_in) == 8'hD0) |-> data_out == flip8(addr[7:0]));

    // R3
    swap_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && $past(data_in) == 8'hD1) |-> data_out == {addr[3:0], addr[7:4]});
endmodule

bind bitmorph_responder bmr_chk #(.ADDR_W(13)) i_bmr_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .data_in (data_in),
    .data_out(data_out),
    .drive_en(drive_en)
);

// File: tb/test_bitmorph_responder.sv
module test_bitmorph_responder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] addr = '0;
    logic [7:0]  data_in = 8'hEA;
    logic [7:0]  data_out;
    logic        drive_en;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    bitmorph_responder i_bitmorph_responder (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .data_in (data_in),
        .data_out(data_out),
        .drive_en(drive_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] rev_exp(input logic [7:0] b);
        logic [7:0] r;
        for (int k = 0; k < 8; k++) r[k] = b[7-k];
        return r;
    endfunction

    task automatic check(input string req, input logic en, input logic [7:0] val);
        total++;
        if (drive_en !== en || data_out !== val) begin
            bad++;
            $display("FAIL %s: drive_en=%0b data_out=%02h expected drive_en=%0b data_out=%02h",
                     req, drive_en, data_out, en, val);
        end
    endtask

    // one bus cycle: drive at falling edge, settle, caller samples before next rising edge
    task automatic bus(input logic [12:0] a, input logic [7:0] d);
        @(negedge clk);
        addr    = a;
        data_in = d;
        #1;
    endtask

    task automatic idle();
        bus(13'h0A00, 8'hEA);
        bus(13'h0A01, 8'hEA);
    endtask

    task automatic t_reset();
        bus(13'h0000, 8'hEA);
        check("R1", 1'b0, 8'h00);
    endtask

    task automatic t_reverse(input logic [12:0] pc, input logic [7:0] lo);
        bus(pc, 8'hBD);
        bus(13'(pc + 1), 8'h00);
        bus(13'(pc + 2), 8'hD0);
        check("R7", 1'b0, 8'h00);
        bus({5'h10, lo}, 8'h00);
        check("R2", 1'b1, rev_exp(lo));
        bus(13'(pc + 3), 8'hBD);
        check("R4", 1'b0, 8'h00);
        idle();
    endtask

    task automatic t_swap(input logic [12:0] pc, input logic [7:0] lo);
        bus(pc, 8'hBD);
        bus(13'(pc + 1), lo);
        bus(13'(pc + 2), 8'hD1);
        bus({5'h11, lo}, 8'h55);
        check("R3", 1'b1, {lo[3:0], lo[7:4]});
        bus(13'(pc + 3), 8'hEA);
        check("R4", 1'b0, 8'h00);
        idle();
    endtask

    task automatic t_other_window(input logic [7:0] hi);
        bus(13'h0200, 8'hBD);
        bus(13'h0201, 8'h23);
        bus(13'h0202, hi);
        bus(13'h0123, 8'h77);
        check("R5", 1'b0, 8'h00);
        idle();
    endtask

    task automatic t_gap();
        bus(13'h0300, 8'hBD);
        bus(13'h0302, 8'h10);
        bus(13'h0303, 8'hD0);
        bus(13'h0010, 8'h00);
        check("R6", 1'b0, 8'h00);
        bus(13'h0400, 8'hBD);
        bus(13'h0401, 8'h10);
        bus(13'h0409, 8'hD0);
        bus(13'h0010, 8'h00);
        check("R6", 1'b0, 8'h00);
        idle();
    endtask

    task automatic t_restart();
        bus(13'h0500, 8'hBD);
        bus(13'h0700, 8'hBD);
        bus(13'h0701, 8'h0F);
        bus(13'h0702, 8'hD1);
        bus(13'h100F, 8'h00);
        check("R8", 1'b1, 8'hF0);
        idle();
    endtask

    task automatic t_wrap();
        bus(13'h1FFE, 8'hBD);
        bus(13'h1FFF, 8'h01);
        bus(13'h0000, 8'hD0);
        bus(13'h1001, 8'h00);
        check("R9", 1'b1, 8'h80);
        idle();
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1;
        check("R1", 1'b0, 8'h00);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_reverse(13'h1000, 8'h01);
        t_reverse(13'h1234, 8'hA6);
        t_reverse(13'h0F00, 8'hF0);
        t_swap(13'h1100, 8'h3C);
        t_swap(13'h1180, 8'h12);
        t_other_window(8'hF1);
        t_other_window(8'hD2);
        t_gap();
        t_restart();
        t_wrap();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule